// File: doc/BRIEF.md
# Radix Page-Table Walker

This block turns an effective address into a real address by walking an in-memory radix tree whose shape is described by the tree itself. A translation starts with a one-cycle `start` pulse. The block first checks that the process ID fits inside the process table. It then fetches the first doubleword of that process's table entry. That doubleword gives the root directory base, the number of index bits at the root and the total address-size value. From there the block descends one directory per memory read until it meets a leaf entry.

Each directory entry chooses the fan-out of the next level, so the tree depth is not fixed. At the leaf, the block merges the page number with the untranslated low address bits and reports the page size as a power of two. It then sets the reference bit, and the change bit for stores. The entry is written back to memory only when its value actually changed.

When relocation is turned off for the access kind, the walk is skipped and a masked copy of the address is returned. Permission checks and filling any translation cache are left to the surrounding logic. Results are held on the outputs from the `done` pulse until the next `start`.

Top module: `rtw_radix_walker`

## Requirements
- R1: Access kind encoding is 0 = load, 1 = store, 2 = fetch. If `xlate_fetch` is 0 for a fetch, or `xlate_data` is 0 for a load or store, no memory is touched. The result is then `ea` with bits 63:60 cleared, fault 0, page shift 12 and `write_ok` 1.
- R2: The process table holds 2^(`ptab_size`+12) bytes and each entry is 16 bytes. If `pid`×16 is at or beyond the table size, the fault is no-entry (code 1) and no memory read is made. Otherwise the doubleword at `ptab_base` + `pid`×16 is read.
- R3: In a process-table doubleword, bits 55:8 (with the low 8 bits taken as zero) are the root directory base, bits 4:0 are the root index bit count and bits 61:56 are the initial remaining size.
- R4: Before each directory read, the block checks the index bit count. If it is below 5, or greater than the remaining size, the walk ends with the bad-configuration fault (code 2) and that read is not issued.
- R5: A directory entry is read at base + 8 × index. The index is `ea` shifted right by (remaining size − index bits) and masked to the index bit count.
- R6: An entry whose bit 63 (valid) is clear ends the walk with the no-entry fault (code 1). After each valid entry, the remaining size drops by that level's index bit count.
- R7: An entry with bit 62 (leaf) set ends the walk with fault 0. `page_shift` equals the reduced remaining size. `real_addr` is the entry's page number (bits 55:12, low 12 bits zero) with its low `page_shift` bits replaced by those of `ea`.
- R8: A valid non-leaf entry gives the next base (bits 55:8, low 8 bits zero) and the next index bit count (bits 4:0). If the fifth entry read in a walk is not a leaf, the result is the bad-configuration fault (code 2).
- R9: On success, `leaf_entry` is the read entry with bit 8 (reference) set and, only for stores, bit 7 (change) set. `write_ok` is 1 only for stores. `leaf_addr` is the address the leaf was read from.
- R10: The updated leaf is written to `leaf_addr` only if it differs from the value read. Otherwise no write is made.
- R11: `rd_req` stays high with a stable `rd_addr` until `rd_valid`, and `wr_req` stays high until `wr_ack`. `done` is a one-cycle pulse. While idle, no read or write is requested. After reset the block is idle with `done` low.
- R12: On any fault, `real_addr`, `page_shift`, `leaf_entry`, `leaf_addr` and `write_ok` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a translation (taken when idle) |
| ea | input | 64 | Effective address |
| acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| pid | input | PID_W | Process ID |
| ptab_base | input | 64 | Process table base address |
| ptab_size | input | 5 | Process table size field |
| xlate_fetch | input | 1 | Relocation enable for fetches |
| xlate_data | input | 1 | Relocation enable for loads and stores |
| busy | output | 1 | A translation is in progress |
| done | output | 1 | Result valid pulse |
| real_addr | output | 64 | Translated address |
| page_shift | output | 6 | log2 of the page size |
| leaf_entry | output | 64 | Leaf entry after reference/change update |
| leaf_addr | output | 64 | Address of the leaf entry |
| fault | output | 2 | 0 none, 1 no-entry, 2 bad-configuration |
| write_ok | output | 1 | Write permission retained |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 64 | Memory read address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 64 | Read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 64 | Memory write address |
| wr_data | output | 64 | Memory write data |
| wr_ack | input | 1 | Write accepted |

## Verification
The assertions check these properties on every cycle:
- The memory request holds steady while it waits for `rd_valid` or `wr_ack`.
- A write-back always carries the reference bit.
- A write-back never flips the change bit for a non-store access.
- A write-back always differs from the entry that was read.
- The level counter never passes the limit, and `done` only pulses.

Other behaviour is visible only through the bench's scenarios against a memory model:
- Correct index arithmetic at each level.
- The merged real address for 4 KiB, 2 MiB and 32 GiB pages.
- Bypass for each access kind.
- Table-bound faults on both sides of the boundary.
- The fifth-level limit.
- Omission of redundant write-backs.

// File: rtl/rtw_pkg.sv
package rtw_pkg;

  localparam int DW = 64;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_NOENT  = 2'd1,
    FLT_BADCFG = 2'd2
  } flt_e;

  localparam int VALID_POS       = 63;
  localparam int LEAF_POS        = 62;
  localparam int REF_POS         = 8;
  localparam int CHG_POS         = 7;
  localparam int MIN_IDX_BITS    = 5;
  localparam int ENTRY_SHIFT     = 3;   // 8-byte directory entries
  localparam int PRT_ENTRY_SHIFT = 4;   // 16-byte process-table entries
  localparam int PRT_MIN_SHIFT   = 12;
  localparam int BYPASS_SHIFT    = 12;
  localparam logic [DW-1:0] BYPASS_MASK = 64'h0FFF_FFFF_FFFF_FFFF;

  function automatic logic [DW-1:0] f_next_base(input logic [DW-1:0] e);
    return {8'h00, e[55:8], 8'h00};
  endfunction

  function automatic logic [4:0] f_idx_bits(input logic [DW-1:0] e);
    return e[4:0];
  endfunction

  function automatic logic [DW-1:0] f_page(input logic [DW-1:0] e);
    return {8'h00, e[55:12], 12'h000};
  endfunction

  function automatic logic [5:0] f_total_size(input logic [DW-1:0] e);
    return e[61:56];
  endfunction

endpackage

// File: rtl/rtw_rst_sync.sv
module rtw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rtw_level_index.sv
module rtw_level_index
  import rtw_pkg::*;
(
  input  logic [DW-1:0] ea,
  input  logic [DW-1:0] base,
  input  logic [4:0]    idx_bits,
  input  logic [5:0]    remain,
  output logic [DW-1:0] ent_addr,
  output logic          cfg_bad
);
  logic [5:0]    shamt;
  logic [DW-1:0] idx_mask;
  logic [DW-1:0] idx;

  always_comb begin
    cfg_bad  = (idx_bits < 5'(MIN_IDX_BITS)) || (6'(idx_bits) > remain);
    shamt    = remain - 6'(idx_bits);
    idx_mask = (64'd1 << idx_bits) - 64'd1;
    idx      = (ea >> shamt) & idx_mask;
    ent_addr = base + (idx << ENTRY_SHIFT);
  end
endmodule

// File: rtl/rtw_leaf_merge.sv
module rtw_leaf_merge
  import rtw_pkg::*;
(
  input  logic [DW-1:0] ea,
  input  logic [DW-1:0] pte,
  input  logic [5:0]    remain,
  input  logic          is_store,
  output logic [DW-1:0] raddr,
  output logic [DW-1:0] new_pte,
  output logic          need_wb,
  output logic          wr_keep
);
  logic [DW-1:0] low_mask;

  always_comb begin
    low_mask         = (64'd1 << remain) - 64'd1;
    raddr            = (f_page(pte) & ~low_mask) | (ea & low_mask);
    new_pte          = pte;
    new_pte[REF_POS] = 1'b1;
    if (is_store) new_pte[CHG_POS] = 1'b1;
    need_wb          = (new_pte != pte);
    wr_keep          = is_store;
  end
endmodule

// File: rtl/rtw_radix_walker.sv
module rtw_radix_walker
  import rtw_pkg::*;
#(
  parameter int PID_W      = 16,
  parameter int MAX_LEVELS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      ea,
  input  logic [1:0]       acc,
  input  logic [PID_W-1:0] pid,
  input  logic [63:0]      ptab_base,
  input  logic [4:0]       ptab_size,
  input  logic             xlate_fetch,
  input  logic             xlate_data,
  output logic             busy,
  output logic             done,
  output logic [63:0]      real_addr,
  output logic [5:0]       page_shift,
  output logic [63:0]      leaf_entry,
  output logic [63:0]      leaf_addr,
  output logic [1:0]       fault,
  output logic             write_ok,
  output logic             rd_req,
  output logic [63:0]      rd_addr,
  input  logic             rd_valid,
  input  logic [63:0]      rd_data,
  output logic             wr_req,
  output logic [63:0]      wr_addr,
  output logic [63:0]      wr_data,
  input  logic             wr_ack
);

  localparam int LVL_W = $clog2(MAX_LEVELS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRT, S_LVL, S_LEAF, S_WB, S_DONE
  } st_e;

  logic rst_n_s;

  rtw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_s)
  );

  st_e           st_q, st_d;
  logic [DW-1:0] ea_q, ea_d;
  acc_e          acc_q, acc_d;
  logic [DW-1:0] base_q, base_d;
  logic [4:0]    nb_q, nb_d;
  logic [5:0]    rem_q, rem_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [DW-1:0] pte_q, pte_d;
  logic [DW-1:0] paddr_q, paddr_d;
  logic [DW-1:0] res_ra_q, res_ra_d;
  logic [5:0]    res_psh_q, res_psh_d;
  logic [DW-1:0] res_ent_q, res_ent_d;
  logic [DW-1:0] res_ead_q, res_ead_d;
  flt_e          res_flt_q, res_flt_d;
  logic          res_wok_q, res_wok_d;
  logic          dp_en;

  // Start-time decisions
  logic          bypass;
  logic [DW-1:0] prt_off;
  logic [DW-1:0] prt_lim;

  always_comb begin
    bypass  = (acc_e'(acc) == ACC_FETCH) ? !xlate_fetch : !xlate_data;
    prt_off = 64'(pid) << PRT_ENTRY_SHIFT;
    prt_lim = 64'd1 << (6'(ptab_size) + 6'(PRT_MIN_SHIFT));
  end

  // Level index and leaf datapath
  logic [DW-1:0] ent_addr;
  logic          cfg_bad;
  logic [DW-1:0] m_raddr, m_new;
  logic          m_need_wb, m_wok;

  rtw_level_index u_idx (
    .ea      (ea_q),
    .base    (base_q),
    .idx_bits(nb_q),
    .remain  (rem_q),
    .ent_addr(ent_addr),
    .cfg_bad (cfg_bad)
  );

  rtw_leaf_merge u_leaf (
    .ea      (ea_q),
    .pte     (pte_q),
    .remain  (rem_q),
    .is_store(acc_q == ACC_STORE),
    .raddr   (m_raddr),
    .new_pte (m_new),
    .need_wb (m_need_wb),
    .wr_keep (m_wok)
  );

  // Next-state logic
  always_comb begin
    st_d      = st_q;
    ea_d      = ea_q;
    acc_d     = acc_q;
    base_d    = base_q;
    nb_d      = nb_q;
    rem_d     = rem_q;
    lvl_d     = lvl_q;
    pte_d     = pte_q;
    paddr_d   = paddr_q;
    res_ra_d  = res_ra_q;
    res_psh_d = res_psh_q;
    res_ent_d = res_ent_q;
    res_ead_d = res_ead_q;
    res_flt_d = res_flt_q;
    res_wok_d = res_wok_q;
    rd_req    = 1'b0;
    rd_addr   = base_q;
    wr_req    = 1'b0;

    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          ea_d      = ea;
          acc_d     = acc_e'(acc);
          res_ra_d  = '0;
          res_psh_d = '0;
          res_ent_d = '0;
          res_ead_d = '0;
          res_wok_d = 1'b0;
          res_flt_d = FLT_NONE;
          if (bypass) begin
            res_ra_d  = ea & BYPASS_MASK;
            res_psh_d = 6'(BYPASS_SHIFT);
            res_wok_d = 1'b1;
            st_d      = S_DONE;
          end else if (prt_off >= prt_lim) begin
            res_flt_d = FLT_NOENT;
            st_d      = S_DONE;
          end else begin
            base_d = ptab_base + prt_off;
            st_d   = S_PRT;
          end
        end
      end

      S_PRT: begin
        rd_req  = 1'b1;
        rd_addr = base_q;
        if (rd_valid) begin
          base_d = f_next_base(rd_data);
          nb_d   = f_idx_bits(rd_data);
          rem_d  = f_total_size(rd_data);
          lvl_d  = '0;
          st_d   = S_LVL;
        end
      end

      S_LVL: begin
        rd_addr = ent_addr;
        if (cfg_bad) begin
          res_flt_d = FLT_BADCFG;
          st_d      = S_DONE;
        end else begin
          rd_req = 1'b1;
          if (rd_valid) begin
            if (!rd_data[VALID_POS]) begin
              res_flt_d = FLT_NOENT;
              st_d      = S_DONE;
            end else if (rd_data[LEAF_POS]) begin
              pte_d   = rd_data;
              paddr_d = ent_addr;
              rem_d   = rem_q - 6'(nb_q);
              st_d    = S_LEAF;
            end else if (lvl_q == LVL_W'(MAX_LEVELS - 1)) begin
              res_flt_d = FLT_BADCFG;
              st_d      = S_DONE;
            end else begin
              base_d = f_next_base(rd_data);
              nb_d   = f_idx_bits(rd_data);
              rem_d  = rem_q - 6'(nb_q);
              lvl_d  = lvl_q + 1'b1;
            end
          end
        end
      end

      S_LEAF: begin
        res_ra_d  = m_raddr;
        res_psh_d = rem_q;
        res_ent_d = m_new;
        res_ead_d = paddr_q;
        res_wok_d = m_wok;
        res_flt_d = FLT_NONE;
        st_d      = m_need_wb ? S_WB : S_DONE;
      end

      S_WB: begin
        wr_req = 1'b1;
        if (wr_ack) st_d = S_DONE;
      end

      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign dp_en = (st_q != S_IDLE) || start;

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ea_q      <= '0;
      acc_q     <= ACC_LOAD;
      base_q    <= '0;
      nb_q      <= '0;
      rem_q     <= '0;
      lvl_q     <= '0;
      pte_q     <= '0;
      paddr_q   <= '0;
      res_ra_q  <= '0;
      res_psh_q <= '0;
      res_ent_q <= '0;
      res_ead_q <= '0;
      res_flt_q <= FLT_NONE;
      res_wok_q <= 1'b0;
    end else if (dp_en) begin
      ea_q      <= ea_d;
      acc_q     <= acc_d;
      base_q    <= base_d;
      nb_q      <= nb_d;
      rem_q     <= rem_d;
      lvl_q     <= lvl_d;
      pte_q     <= pte_d;
      paddr_q   <= paddr_d;
      res_ra_q  <= res_ra_d;
      res_psh_q <= res_psh_d;
      res_ent_q <= res_ent_d;
      res_ead_q <= res_ead_d;
      res_flt_q <= res_flt_d;
      res_wok_q <= res_wok_d;
    end
  end

  assign busy       = (st_q != S_IDLE);
  assign done       = (st_q == S_DONE);
  assign real_addr  = res_ra_q;
  assign page_shift = res_psh_q;
  assign leaf_entry = res_ent_q;
  assign leaf_addr  = res_ead_q;
  assign fault      = res_flt_q;
  assign write_ok   = res_wok_q;
  assign wr_addr    = res_ead_q;
  assign wr_data    = res_ent_q;

  // Assertions
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> (!rd_req && !wr_req));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);

  assert_wb_changed_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_req |-> (wr_data != pte_q));

  assert_ref_set_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_req |-> wr_data[REF_POS]);

  assert_chg_store_only_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_req && (acc_q != ACC_STORE)) |-> (wr_data[CHG_POS] == pte_q[CHG_POS]));

  assert_lvl_bound_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == S_LVL) |-> (lvl_q < LVL_W'(MAX_LEVELS)));

endmodule

// File: tb/tb_rtw_radix_walker.sv
module tb_rtw_radix_walker;

  localparam logic [63:0] PTB = 64'h1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [63:0] ea;
  logic [1:0]  acc;
  logic [15:0] pid;
  logic [63:0] ptab_base;
  logic [4:0]  ptab_size;
  logic        xlate_fetch, xlate_data;
  logic        busy, done;
  logic [63:0] real_addr, leaf_entry, leaf_addr;
  logic [5:0]  page_shift;
  logic [1:0]  fault;
  logic        write_ok;
  logic        rd_req, rd_valid, wr_req, wr_ack;
  logic [63:0] rd_addr, rd_data, wr_addr, wr_data;

  always #5 clk = ~clk;

  rtw_radix_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .acc(acc), .pid(pid),
    .ptab_base(ptab_base), .ptab_size(ptab_size),
    .xlate_fetch(xlate_fetch), .xlate_data(xlate_data),
    .busy(busy), .done(done), .real_addr(real_addr), .page_shift(page_shift),
    .leaf_entry(leaf_entry), .leaf_addr(leaf_addr), .fault(fault), .write_ok(write_ok),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] a, logic [63:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, a, e);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Memory model
  logic [63:0] mem [logic [63:0]];
  int rd_cnt = 0, wr_cnt = 0, lat = 1, lat_c = 0;

  function automatic logic [63:0] mget(logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  always @(negedge clk) begin
    if (rd_valid) begin
      rd_valid = 1'b0;
      lat_c = 0;
    end else if (rd_req) begin
      if (lat_c >= lat) begin
        rd_valid = 1'b1;
        rd_data  = mget(rd_addr);
        rd_cnt++;
      end else lat_c++;
    end
    if (wr_ack) wr_ack = 1'b0;
    else if (wr_req) begin
      mem[wr_addr] = wr_data;
      wr_ack = 1'b1;
      wr_cnt++;
    end
  end

  // Entry builders (field positions per R3, R6, R7, R8)
  function automatic logic [63:0] dir_e(logic [63:0] b, int nb);
    return 64'h8000_0000_0000_0000 | (b & 64'h00FF_FFFF_FFFF_FF00) | 64'(nb);
  endfunction
  function automatic logic [63:0] leaf_e(logic [63:0] pg, bit r, bit c);
    return 64'hC000_0000_0000_0000 | (pg & 64'h00FF_FFFF_FFFF_F000) |
           (64'(r) << 8) | (64'(c) << 7);
  endfunction
  function automatic logic [63:0] prt_e(int rts, logic [63:0] b, int nb);
    return (64'(rts) << 56) | (b & 64'h00FF_FFFF_FFFF_FF00) | 64'(nb);
  endfunction
  function automatic logic [63:0] slot(logic [63:0] b, logic [63:0] e, int rem, int nb);
    return b + (((e >> (rem - nb)) & ((64'd1 << nb) - 64'd1)) << 3);
  endfunction

  // Expected-result model built from the requirements
  typedef struct {
    string       tag;
    logic [63:0] ra;
    logic [5:0]  psh;
    logic [63:0] ent;
    logic [63:0] ead;
    logic [1:0]  flt;
    logic        wok;
    int          nrd;
    int          nwr;
  } exp_t;

  exp_t sbq[$];

  function automatic exp_t model(logic [63:0] e, logic [1:0] k, int p, int sz, bit xf, bit xd);
    exp_t r;
    logic [63:0] pe, d, nd, base, a, off, mask;
    int nb, rem;
    r.tag = ""; r.ra = 0; r.psh = 0; r.ent = 0; r.ead = 0; r.flt = 0; r.wok = 0;
    r.nrd = 0; r.nwr = 0;
    if ((k == 2'd2 && !xf) || (k != 2'd2 && !xd)) begin
      r.ra = e & 64'h0FFF_FFFF_FFFF_FFFF; r.psh = 12; r.wok = 1;
      return r;
    end
    off = 64'(p) * 64'd16;
    if (off >= (64'd1 << (sz + 12))) begin r.flt = 1; return r; end
    pe = mget(PTB + off); r.nrd = 1;
    base = pe & 64'h00FF_FFFF_FFFF_FF00; nb = int'(pe[4:0]); rem = int'(pe[61:56]);
    for (int lv = 0; lv < 5; lv++) begin
      if (nb < 5 || nb > rem) begin r.flt = 2; return r; end
      a = slot(base, e, rem, nb);
      d = mget(a); r.nrd++;
      if (!d[63]) begin r.flt = 1; return r; end
      rem = rem - nb;
      if (d[62]) begin
        mask = (64'd1 << rem) - 64'd1;
        r.ra  = ((d & 64'h00FF_FFFF_FFFF_F000) & ~mask) | (e & mask);
        r.psh = 6'(rem);
        nd = d; nd[8] = 1'b1;
        if (k == 2'd1) nd[7] = 1'b1;
        r.ent = nd; r.ead = a; r.wok = (k == 2'd1);
        r.nwr = (nd != d) ? 1 : 0;
        return r;
      end
      base = d & 64'h00FF_FFFF_FFFF_FF00; nb = int'(d[4:0]);
    end
    r.flt = 2;
    return r;
  endfunction

  // Driver: push expectation, pulse start, wait for idle
  task automatic run(logic [63:0] e, logic [1:0] k, int p, int sz, bit xf, bit xd, string tag);
    exp_t x;
    x = model(e, k, p, sz, xf, xd);
    x.tag = tag;
    x.nrd += rd_cnt;
    x.nwr += wr_cnt;
    sbq.push_back(x);
    @(negedge clk);
    ea = e; acc = k; pid = 16'(p); ptab_size = 5'(sz);
    xlate_fetch = xf; xlate_data = xd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    exp_t x;
    if (rst_n && done) begin
      if (sbq.size() == 0) chk(0, "R11", "unexpected done", 1, 0);
      else begin
        x = sbq.pop_front();
        chk(real_addr == x.ra,   x.tag, "real_addr",  real_addr, x.ra);
        chk(page_shift == x.psh, x.tag, "page_shift", 64'(page_shift), 64'(x.psh));
        chk(fault == x.flt,      x.tag, "fault",      64'(fault), 64'(x.flt));
        chk(write_ok == x.wok,   x.tag, "write_ok",   64'(write_ok), 64'(x.wok));
        chk(leaf_entry == x.ent, x.tag, "leaf_entry", leaf_entry, x.ent);
        chk(leaf_addr == x.ead,  x.tag, "leaf_addr",  leaf_addr, x.ead);
        chk(rd_cnt == x.nrd,     x.tag, "read count", 64'(rd_cnt), 64'(x.nrd));
        chk(wr_cnt == x.nwr,     x.tag, "write count (R10)", 64'(wr_cnt), 64'(x.nwr));
        if (x.flt == 0 && x.ead != 0)
          chk(mget(x.ead) == x.ent, x.tag, "stored leaf (R10)", mget(x.ead), x.ent);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "R11", "watchdog expired", 0, 1);
    report();
  end

  localparam logic [63:0] EA_F = 64'hF234_5678_9ABC_DEF0;
  localparam logic [63:0] EA_A = 64'h0000_0000_2345_6789;
  localparam logic [63:0] EA_B = 64'h0000_0000_1357_9BDF;
  localparam logic [63:0] EA_C = 64'h0ABC_DEF0_1234_5678;

  initial begin
    rst_n = 1'b0; start = 1'b0; ea = '0; acc = '0; pid = '0;
    ptab_base = PTB; ptab_size = '0; xlate_fetch = 1'b1; xlate_data = 1'b1;
    rd_valid = 1'b0; rd_data = '0; wr_ack = 1'b0;

    // pid 1: two-level walk to a 4 KiB page
    mem[PTB + 16*1] = prt_e(30, 64'h10000, 9);
    mem[slot(64'h10000, EA_A, 30, 9)] = dir_e(64'h20000, 9);
    mem[slot(64'h20000, EA_A, 21, 9)] = leaf_e(64'h0000_0456_7890_A000, 0, 0);
    // pid 256 (only inside a larger table): same root as pid 1
    mem[PTB + 16*256] = prt_e(30, 64'h10000, 9);
    // pid 2: leaf at root -> 2 MiB page, reference already set
    mem[PTB + 16*2] = prt_e(30, 64'h30000, 9);
    mem[slot(64'h30000, EA_B, 30, 9)] = leaf_e(64'h0000_0000_407F_F000, 1, 0);
    // pid 3: empty root; pid 4: too few index bits; pid 5: more bits than size
    mem[PTB + 16*3] = prt_e(30, 64'h38000, 9);
    mem[PTB + 16*4] = prt_e(30, 64'h3A000, 4);
    mem[PTB + 16*5] = prt_e(10, 64'h3C000, 12);
    // pid 6: five non-leaf levels; pid 7: leaf found at the fifth level
    mem[PTB + 16*6] = prt_e(60, 64'h40000, 5);
    mem[PTB + 16*7] = prt_e(60, 64'h50000, 5);
    for (int t = 0; t < 5; t++) begin
      for (int s = 0; s < 32; s++) begin
        mem[64'h40000 + 64'(t)*64'h1000 + 64'(s)*8] =
          dir_e(64'h40000 + 64'((t + 1) % 5)*64'h1000, 5);
        mem[64'h50000 + 64'(t)*64'h1000 + 64'(s)*8] = (t == 4) ?
          leaf_e(64'h0000_0080_0000_0000, 0, 0) :
          dir_e(64'h50000 + 64'(t + 1)*64'h1000, 5);
      end
    end

    repeat (4) @(negedge clk);
    // R11: reset state
    chk(!busy,   "R11", "busy in reset",   64'(busy), 0);
    chk(!done,   "R11", "done in reset",   64'(done), 0);
    chk(!rd_req, "R11", "rd_req in reset", 64'(rd_req), 0);
    chk(!wr_req, "R11", "wr_req in reset", 64'(wr_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R11", "idle after reset", 64'(busy), 0);

    run(EA_F, 2'd0, 1, 0, 1, 0, "R1 load bypass");
    run(EA_F, 2'd2, 1, 0, 0, 1, "R1 fetch bypass");
    run(EA_A, 2'd0, 1, 0, 1, 1, "R3/R5/R7/R9 load walk");
    run(EA_A, 2'd0, 1, 0, 1, 1, "R10 repeat load no write");
    run(EA_A, 2'd1, 1, 0, 1, 1, "R9 store sets change");
    run(EA_A, 2'd1, 1, 0, 1, 1, "R10 repeat store no write");
    run(EA_A, 2'd2, 1, 0, 1, 0, "R1 fetch translated");
    run(EA_B, 2'd0, 2, 0, 1, 1, "R7 large page");
    run(EA_B, 2'd1, 2, 0, 1, 1, "R9 large page store");
    run(EA_A, 2'd0, 3, 0, 1, 1, "R6/R12 invalid entry");
    run(EA_A, 2'd0, 4, 0, 1, 1, "R4/R12 index bits below 5");
    run(EA_A, 2'd1, 5, 0, 1, 1, "R4 index bits over size");
    run(EA_C, 2'd0, 6, 0, 1, 1, "R8 level limit");
    run(EA_C, 2'd1, 7, 0, 1, 1, "R8 leaf at fifth level");
    run(EA_A, 2'd0, 256, 0, 1, 1, "R2 offset at table end");
    run(EA_A, 2'd0, 256, 1, 1, 1, "R2 offset inside larger table");
    lat = 4;
    run(EA_C, 2'd2, 7, 0, 1, 1, "R11 slow memory");
    lat = 1;

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R11", "pending results", 64'(sbq.size()), 0);
    report();
  end

endmodule